// File: doc/BRIEF.md
# Memory ECC Error Capture and Injection Unit

This block sits next to the ECC decoder and encoder of a 64-bit DRAM data path. On each read beat the decoder reports whether it saw a correctable (single-bit) or uncorrectable (multi-bit) error, together with the beat's data, check bits and address. The unit keeps sticky flags for both error classes. It counts correctable errors against a programmable threshold. It freezes a snapshot of the first failing beat and drives one interrupt line. Software reads the snapshot and clears the flags by writing ones to them.

For testing the error handling, the unit also carries three injection masks: one for the upper data word, one for the lower data word and one for the check byte. While injection is enabled, every valid write beat that passes through the unit has these masks XORed in. The read path is only observed and is never modified.

All control and status goes through a 32-bit word-addressed register port. Writes take effect on the clock edge. Read data is a combinational decode of the selected register.

Top module: `memerr_unit`

## Requirements
- R1: After reset, every register reads zero, the interrupt is low, and the injection path passes data and check bits through unchanged.
- R2: A valid read beat with the multi-bit indication sets status bit 1 on that clock edge, unless disable bit 1 is set. A beat that reports both classes counts only as multi-bit.
- R3: Each valid correctable beat (status-side disable bit 0 clear) advances a counter, readable in SBECTL bits 7:0. The threshold is SBECTL bits 23:16, and a threshold of 0 behaves as 1. The beat that brings the count to the threshold sets status bit 0 and returns the counter to zero. Any write to SBECTL zeroes the counter.
- R4: The status register (offset 0) clears each flag written with a one and ignores zeros, so writing all ones clears everything. A flag that an error sets in the same cycle as a clear stays set.
- R5: Disable register (offset 1) bit 0 stops correctable beats from counting or flagging. Bit 1 stops multi-bit beats from flagging. The value 0 enables both classes.
- R6: The interrupt is high exactly while some status bit is set together with the same bit of the interrupt-enable register (offset 2). Bit 0 covers correctable errors and bit 1 covers multi-bit errors.
- R7: The beat that sets a flag while status is zero loads the capture registers: upper data word (offset 4), lower data word (offset 5), check field (offset 6), address bits 31:0 (offset 7), and the address bits above 31, zero-extended (offset 8).
- R8: While any status flag is set, the capture registers hold their value. A later error sets only its own flag.
- R9: With the narrow-bus input high, the captured check field holds all 16 check bits. With it low, only bits 7:0 are captured and bits 15:8 read zero.
- R10: The injection masks read back from offsets 9 (upper word), 10 (lower word) and 11 (control: bits 7:0 check mask, bit 8 enable, all other bits zero).
- R11: While the injection enable is set and a write beat is valid, the output data equals the input data XOR {upper mask, lower mask}, and the output check byte equals the input check byte XOR the check mask. Otherwise data and check bits pass through unchanged. Read beats and their captured values are never altered.
- R12: Offsets 12 to 15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data of selected offset |
| bus_narrow | input | 1 | High when the DRAM bus runs 32 bits wide |
| chk_valid | input | 1 | Read beat status valid |
| chk_sbe | input | 1 | Beat had a correctable error |
| chk_mbe | input | 1 | Beat had an uncorrectable error |
| chk_data | input | 64 | Beat data as received |
| chk_ecc | input | 16 | Beat check bits as received |
| chk_addr | input | ADDR_W | Beat address |
| wr_valid | input | 1 | Write beat valid |
| wr_data_in | input | 64 | Write data from the encoder |
| wr_ecc_in | input | 8 | Write check byte from the encoder |
| wr_data_out | output | 64 | Write data toward DRAM |
| wr_ecc_out | output | 8 | Write check byte toward DRAM |
| irq | output | 1 | Error interrupt |

## Verification
On every cycle the assertions check several rules. A multi-bit beat always raises its flag. The correctable counter never reaches its threshold. Writing all ones to status empties it. A disabled correctable beat leaves the counter alone. An enabled multi-bit beat raises the interrupt. Capture registers hold while a flag is set. With injection off, the write data passes through. Only the bench scenarios show the rest. They sweep thresholds to show the exact beat on which the flag appears. They show which beat's values end up in the capture registers after unfreezing. They show how the check field is masked in each bus mode. They show that each of the 72 injection mask bits flips exactly its own output bit.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  localparam int WORD_W   = 32;
  localparam int NWORDS   = 2;
  localparam int DATA_W   = WORD_W * NWORDS;
  localparam int CHK_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int THR_W    = 8;
  localparam int THR_LSB  = 16;
  localparam int INJ_EN_B = 8;
  localparam int NFLAGS   = 2;
  localparam int REG_AW   = 4;

  localparam int FLAG_SBE = 0;
  localparam int FLAG_MBE = 1;

  localparam logic [REG_AW-1:0] OFS_STATUS = 4'd0;
  localparam logic [REG_AW-1:0] OFS_DIS    = 4'd1;
  localparam logic [REG_AW-1:0] OFS_INTEN  = 4'd2;
  localparam logic [REG_AW-1:0] OFS_SBECTL = 4'd3;
  localparam logic [REG_AW-1:0] OFS_CAPHI  = 4'd4;
  localparam logic [REG_AW-1:0] OFS_CAPLO  = 4'd5;
  localparam logic [REG_AW-1:0] OFS_CAPCHK = 4'd6;
  localparam logic [REG_AW-1:0] OFS_CAPAD  = 4'd7;
  localparam logic [REG_AW-1:0] OFS_CAPEXT = 4'd8;
  localparam logic [REG_AW-1:0] OFS_INJHI  = 4'd9;
  localparam logic [REG_AW-1:0] OFS_INJLO  = 4'd10;
  localparam logic [REG_AW-1:0] OFS_INJCTL = 4'd11;

  typedef logic [NFLAGS-1:0] flags_t;
endpackage

// File: rtl/memerr_sbe_ctr.sv
module memerr_sbe_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic             clr,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thr_eff;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    thr_eff = (thr == '0) ? CNT_W'(1) : thr;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    cnt_d   = cnt_q;
    hit     = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (bump) begin
      if (cnt_inc >= {1'b0, thr_eff}) begin
        cnt_d = '0;
        hit   = 1'b1;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr || bump) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/memerr_capture.sv
module memerr_capture
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              narrow,
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] cap_hi,
  output logic [WORD_W-1:0] cap_lo,
  output logic [WORD_W-1:0] cap_chk,
  output logic [WORD_W-1:0] cap_addr,
  output logic [WORD_W-1:0] cap_ext
);
  logic [WORD_W-1:0] chk_d, addr_lo_d, addr_ext_d;
  logic [WORD_W-1:0] hi_q, lo_q, chk_q, ad_q, ext_q;

  always_comb begin
    chk_d = narrow ? WORD_W'(chk) : WORD_W'(chk[BYTE_W-1:0]);
  end

  generate
    if (ADDR_W > WORD_W) begin : g_wide_addr
      assign addr_lo_d  = addr[WORD_W-1:0];
      assign addr_ext_d = WORD_W'(addr[ADDR_W-1:WORD_W]);
    end else begin : g_narrow_addr
      assign addr_lo_d  = WORD_W'(addr);
      assign addr_ext_d = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      chk_q <= '0;
      ad_q  <= '0;
      ext_q <= '0;
    end else if (load) begin
      hi_q  <= data[DATA_W-1:WORD_W];
      lo_q  <= data[WORD_W-1:0];
      chk_q <= chk_d;
      ad_q  <= addr_lo_d;
      ext_q <= addr_ext_d;
    end
  end

  assign cap_hi   = hi_q;
  assign cap_lo   = lo_q;
  assign cap_chk  = chk_q;
  assign cap_addr = ad_q;
  assign cap_ext  = ext_q;
endmodule

// File: rtl/memerr_inject.sv
module memerr_inject
  import memerr_pkg::*;
(
  input  logic              act,
  input  logic [DATA_W-1:0] mask,
  input  logic [BYTE_W-1:0] ecc_mask,
  input  logic [DATA_W-1:0] data_in,
  input  logic [BYTE_W-1:0] ecc_in,
  output logic [DATA_W-1:0] data_out,
  output logic [BYTE_W-1:0] ecc_out
);
  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      assign data_out[w*WORD_W +: WORD_W] =
        data_in[w*WORD_W +: WORD_W] ^ (act ? mask[w*WORD_W +: WORD_W] : '0);
    end
  endgenerate

  assign ecc_out = ecc_in ^ (act ? ecc_mask : '0);
endmodule

// File: rtl/memerr_unit.sv
module memerr_unit
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bus_narrow,
  input  logic              chk_valid,
  input  logic              chk_sbe,
  input  logic              chk_mbe,
  input  logic [63:0]       chk_data,
  input  logic [15:0]       chk_ecc,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              wr_valid,
  input  logic [63:0]       wr_data_in,
  input  logic [7:0]        wr_ecc_in,
  output logic [63:0]       wr_data_out,
  output logic [7:0]        wr_ecc_out,
  output logic              irq
);
  localparam int INJCTL_W = INJ_EN_B + 1;

  flags_t            status_q, status_d, dis_q, dis_d, inten_q, inten_d;
  flags_t            clr_mask, set_mask;
  logic [THR_W-1:0]  thr_q, thr_d;
  logic [WORD_W-1:0] inj_hi_q, inj_hi_d, inj_lo_q, inj_lo_d;
  logic [INJCTL_W-1:0] inj_ctl_q, inj_ctl_d;
  logic              wr_status, wr_dis, wr_inten, wr_sbectl;
  logic              wr_injhi, wr_injlo, wr_injctl;
  logic              sbe_bump, sbe_hit, mbe_set, cap_load;
  logic [THR_W-1:0]  cnt;
  logic [WORD_W-1:0] cap_hi, cap_lo, cap_chk, cap_addr, cap_ext;

  // register write decode
  always_comb begin
    wr_status = reg_wen && (reg_addr == OFS_STATUS);
    wr_dis    = reg_wen && (reg_addr == OFS_DIS);
    wr_inten  = reg_wen && (reg_addr == OFS_INTEN);
    wr_sbectl = reg_wen && (reg_addr == OFS_SBECTL);
    wr_injhi  = reg_wen && (reg_addr == OFS_INJHI);
    wr_injlo  = reg_wen && (reg_addr == OFS_INJLO);
    wr_injctl = reg_wen && (reg_addr == OFS_INJCTL);
  end

  // error event classification; multi-bit takes precedence
  always_comb begin
    mbe_set  = chk_valid && chk_mbe && !dis_q[FLAG_MBE];
    sbe_bump = chk_valid && chk_sbe && !chk_mbe && !dis_q[FLAG_SBE];
  end

  memerr_sbe_ctr #(.CNT_W(THR_W)) i_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (sbe_bump),
    .clr   (wr_sbectl),
    .thr   (thr_q),
    .cnt   (cnt),
    .hit   (sbe_hit)
  );

  // next-state for control and status registers
  always_comb begin
    clr_mask = wr_status ? reg_wdata[NFLAGS-1:0] : '0;
    set_mask = '0;
    set_mask[FLAG_SBE] = sbe_hit;
    set_mask[FLAG_MBE] = mbe_set;
    status_d  = (status_q & ~clr_mask) | set_mask;
    cap_load  = (set_mask != '0) && (status_q == '0);
    dis_d     = wr_dis    ? reg_wdata[NFLAGS-1:0] : dis_q;
    inten_d   = wr_inten  ? reg_wdata[NFLAGS-1:0] : inten_q;
    thr_d     = wr_sbectl ? reg_wdata[THR_LSB +: THR_W] : thr_q;
    inj_hi_d  = wr_injhi  ? reg_wdata : inj_hi_q;
    inj_lo_d  = wr_injlo  ? reg_wdata : inj_lo_q;
    inj_ctl_d = wr_injctl ? reg_wdata[INJCTL_W-1:0] : inj_ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      dis_q     <= '0;
      inten_q   <= '0;
      thr_q     <= '0;
      inj_hi_q  <= '0;
      inj_lo_q  <= '0;
      inj_ctl_q <= '0;
    end else begin
      status_q <= status_d;
      if (wr_dis)    dis_q     <= dis_d;
      if (wr_inten)  inten_q   <= inten_d;
      if (wr_sbectl) thr_q     <= thr_d;
      if (wr_injhi)  inj_hi_q  <= inj_hi_d;
      if (wr_injlo)  inj_lo_q  <= inj_lo_d;
      if (wr_injctl) inj_ctl_q <= inj_ctl_d;
    end
  end

  memerr_capture #(.ADDR_W(ADDR_W)) i_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cap_load),
    .narrow   (bus_narrow),
    .data     (chk_data),
    .chk      (chk_ecc),
    .addr     (chk_addr),
    .cap_hi   (cap_hi),
    .cap_lo   (cap_lo),
    .cap_chk  (cap_chk),
    .cap_addr (cap_addr),
    .cap_ext  (cap_ext)
  );

  memerr_inject i_inj (
    .act      (wr_valid && inj_ctl_q[INJ_EN_B]),
    .mask     ({inj_hi_q, inj_lo_q}),
    .ecc_mask (inj_ctl_q[BYTE_W-1:0]),
    .data_in  (wr_data_in),
    .ecc_in   (wr_ecc_in),
    .data_out (wr_data_out),
    .ecc_out  (wr_ecc_out)
  );

  // read decode
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_STATUS: reg_rdata = 32'(status_q);
      OFS_DIS:    reg_rdata = 32'(dis_q);
      OFS_INTEN:  reg_rdata = 32'(inten_q);
      OFS_SBECTL: reg_rdata = {8'h00, thr_q, 8'h00, cnt};
      OFS_CAPHI:  reg_rdata = cap_hi;
      OFS_CAPLO:  reg_rdata = cap_lo;
      OFS_CAPCHK: reg_rdata = cap_chk;
      OFS_CAPAD:  reg_rdata = cap_addr;
      OFS_CAPEXT: reg_rdata = cap_ext;
      OFS_INJHI:  reg_rdata = inj_hi_q;
      OFS_INJLO:  reg_rdata = inj_lo_q;
      OFS_INJCTL: reg_rdata = 32'(inj_ctl_q);
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = |(status_q & inten_q);
endmodule

// File: rtl/memerr_chk.sv
module memerr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reg_addr,
  input logic        reg_wen,
  input logic [1:0]  wdata_lo,
  input logic        chk_valid,
  input logic        chk_sbe,
  input logic        chk_mbe,
  input logic [1:0]  dis,
  input logic [1:0]  inten,
  input logic [1:0]  status,
  input logic [7:0]  thr,
  input logic [7:0]  cnt,
  input logic [31:0] cap_hi,
  input logic        inj_en,
  input logic        wr_valid,
  input logic [63:0] wr_data_in,
  input logic [63:0] wr_data_out,
  input logic        irq
);
  // R2
  mbe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_mbe && !dis[1]) |=> status[1]);

  // R3
  cnt_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ((thr == 8'd0) ? 8'd1 : thr));

  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == 4'd0 && wdata_lo == 2'b11 && !chk_valid) |=> (status == 2'b00));

  // R5
  sbe_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_sbe && dis[0] && !(reg_wen && reg_addr == 4'd3)) |=> $stable(cnt));

  // R6
  irq_mbe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_mbe && !dis[1] && inten[1] && !(reg_wen && reg_addr == 4'd2)) |=> irq);

  // R8
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b00) |=> $stable(cap_hi));

  // R11
  inject_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inj_en && wr_valid) |-> (wr_data_out == wr_data_in));
endmodule

bind memerr_unit memerr_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wen     (reg_wen),
  .wdata_lo    (reg_wdata[1:0]),
  .chk_valid   (chk_valid),
  .chk_sbe     (chk_sbe),
  .chk_mbe     (chk_mbe),
  .dis         (dis_q),
  .inten       (inten_q),
  .status      (status_q),
  .thr         (thr_q),
  .cnt         (cnt),
  .cap_hi      (cap_hi),
  .inj_en      (inj_ctl_q[8]),
  .wr_valid    (wr_valid),
  .wr_data_in  (wr_data_in),
  .wr_data_out (wr_data_out),
  .irq         (irq)
);

// File: tb/test_memerr_unit.sv
module test_memerr_unit;
  logic        clk;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wen;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        bus_narrow;
  logic        chk_valid, chk_sbe, chk_mbe;
  logic [63:0] chk_data;
  logic [15:0] chk_ecc;
  logic [35:0] chk_addr;
  logic        wr_valid;
  logic [63:0] wr_data_in, wr_data_out;
  logic [7:0]  wr_ecc_in, wr_ecc_out;
  logic        irq;

  int tests = 0;
  int fails = 0;

  memerr_unit #(.ADDR_W(36)) i_memerr_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_narrow(bus_narrow),
    .chk_valid(chk_valid), .chk_sbe(chk_sbe), .chk_mbe(chk_mbe),
    .chk_data(chk_data), .chk_ecc(chk_ecc), .chk_addr(chk_addr),
    .wr_valid(wr_valid), .wr_data_in(wr_data_in), .wr_ecc_in(wr_ecc_in),
    .wr_data_out(wr_data_out), .wr_ecc_out(wr_ecc_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic beat(input logic s, input logic m, input logic [63:0] d,
                      input logic [15:0] e, input logic [35:0] a);
    @(negedge clk);
    chk_valid = 1'b1; chk_sbe = s; chk_mbe = m;
    chk_data = d; chk_ecc = e; chk_addr = a;
    @(negedge clk);
    chk_valid = 1'b0; chk_sbe = 1'b0; chk_mbe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] pat;
    rst_n = 1'b0; reg_addr = '0; reg_wen = 1'b0; reg_wdata = '0;
    bus_narrow = 1'b0; chk_valid = 1'b0; chk_sbe = 1'b0; chk_mbe = 1'b0;
    chk_data = '0; chk_ecc = '0; chk_addr = '0;
    wr_valid = 1'b0; wr_data_in = '0; wr_ecc_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all offsets zero, irq low, passthrough
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r);
      check($sformatf("R1 reset offset %0d", a), 64'(r), 64'h0);
    end
    check("R1 irq after reset", 64'(irq), 64'h0);
    wr_valid = 1'b1; wr_data_in = 64'hDEAD_BEEF_0BAD_F00D; wr_ecc_in = 8'h5A; #1;
    check("R1 data passthrough", wr_data_out, 64'hDEAD_BEEF_0BAD_F00D);
    check("R1 ecc passthrough", 64'(wr_ecc_out), 64'h5A);
    wr_valid = 1'b0;

    // R3 / R7: threshold sweep, capture on flag-setting beat
    for (int t = 1; t <= 5; t++) begin
      wr(4'd3, 32'(t) << 16);
      for (int k = 1; k <= t; k++) begin
        beat(1'b1, 1'b0, {32'(k), 32'(t)}, 16'(k), 36'(k));
        rd(4'd0, r);
        check($sformatf("R3 flag t=%0d k=%0d", t, k), 64'(r), (k == t) ? 64'h1 : 64'h0);
        rd(4'd3, r);
        check($sformatf("R3 count t=%0d k=%0d", t, k), 64'(r),
              64'((32'(t) << 16) | ((k == t) ? 0 : k)));
      end
      rd(4'd4, r); check($sformatf("R7 cap hi t=%0d", t), 64'(r), 64'(t));
      rd(4'd5, r); check($sformatf("R7 cap lo t=%0d", t), 64'(r), 64'(t));
      rd(4'd6, r); check($sformatf("R7 cap chk t=%0d", t), 64'(r), 64'(t));
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, r); check($sformatf("R4 clear all t=%0d", t), 64'(r), 64'h0);
    end

    // R3: threshold 0 acts as 1; SBECTL write zeroes count
    wr(4'd3, 32'h0);
    beat(1'b1, 1'b0, 64'h1, 16'h1, 36'h1);
    rd(4'd0, r); check("R3 threshold zero flags", 64'(r), 64'h1);
    wr(4'd0, 32'h1);
    wr(4'd3, 32'h0004_0000);
    beat(1'b1, 1'b0, 64'h1, 16'h1, 36'h1);
    beat(1'b1, 1'b0, 64'h1, 16'h1, 36'h1);
    rd(4'd3, r); check("R3 count two", 64'(r), 64'h0004_0002);
    wr(4'd3, 32'h0004_0000);
    rd(4'd3, r); check("R3 write zeroes count", 64'(r), 64'h0004_0000);

    // R7 / R8: address capture, freeze, separate flags
    wr(4'd3, 32'h0001_0000);
    beat(1'b1, 1'b0, 64'h1111_2222_3333_4444, 16'h00AA, 36'h9_1234_5678);
    rd(4'd7, r); check("R7 cap addr low", 64'(r), 64'h1234_5678);
    rd(4'd8, r); check("R7 cap addr ext", 64'(r), 64'h9);
    beat(1'b0, 1'b1, 64'h5555_6666_7777_8888, 16'h00BB, 36'h1_0000_0000);
    rd(4'd0, r); check("R8 both flags", 64'(r), 64'h3);
    rd(4'd4, r); check("R8 cap hi frozen", 64'(r), 64'h1111_2222);
    rd(4'd7, r); check("R8 cap addr frozen", 64'(r), 64'h1234_5678);
    wr(4'd0, 32'h1);
    rd(4'd0, r); check("R4 clear only bit0", 64'(r), 64'h2);

    // R6: interrupt gating
    check("R6 irq off when disabled", 64'(irq), 64'h0);
    wr(4'd2, 32'h1); #1;
    check("R6 irq wrong enable", 64'(irq), 64'h0);
    wr(4'd2, 32'h2); #1;
    check("R6 irq mbe enabled", 64'(irq), 64'h1);

    // R4: set wins over same-cycle clear
    @(negedge clk);
    reg_addr = 4'd0; reg_wdata = 32'h2; reg_wen = 1'b1;
    chk_valid = 1'b1; chk_mbe = 1'b1; chk_sbe = 1'b0;
    @(negedge clk);
    reg_wen = 1'b0; chk_valid = 1'b0; chk_mbe = 1'b0;
    rd(4'd0, r); check("R4 set beats clear", 64'(r), 64'h2);
    wr(4'd0, 32'hFFFF_FFFF); #1;
    check("R6 irq drops on clear", 64'(irq), 64'h0);
    wr(4'd2, 32'h0);

    // R5: disable masks
    wr(4'd3, 32'h0002_0000);
    wr(4'd1, 32'h1);
    beat(1'b1, 1'b0, 64'h1, 16'h1, 36'h1);
    rd(4'd3, r); check("R5 disabled sbe no count", 64'(r), 64'h0002_0000);
    beat(1'b0, 1'b1, 64'h1, 16'h1, 36'h1);
    rd(4'd0, r); check("R5 mbe still flags", 64'(r), 64'h2);
    wr(4'd0, 32'h2);
    wr(4'd1, 32'h3);
    beat(1'b0, 1'b1, 64'h1, 16'h1, 36'h1);
    rd(4'd0, r); check("R5 mbe disabled", 64'(r), 64'h0);
    wr(4'd1, 32'h0);

    // R2: both classes in one beat count as mbe only
    beat(1'b1, 1'b1, 64'h2, 16'h2, 36'h2);
    rd(4'd0, r); check("R2 dual beat mbe only", 64'(r), 64'h2);
    rd(4'd3, r); check("R2 dual beat no count", 64'(r), 64'h0002_0000);
    wr(4'd0, 32'h3);

    // R9: check-field width per bus mode
    bus_narrow = 1'b1;
    beat(1'b0, 1'b1, 64'h3, 16'hABCD, 36'h3);
    rd(4'd6, r); check("R9 narrow check field", 64'(r), 64'hABCD);
    wr(4'd0, 32'h3);
    bus_narrow = 1'b0;
    beat(1'b0, 1'b1, 64'h3, 16'hABCD, 36'h3);
    rd(4'd6, r); check("R9 wide check field", 64'(r), 64'hCD);
    wr(4'd0, 32'h3);

    // R10: readback
    wr(4'd9, 32'hA5A5_0F0F);
    wr(4'd10, 32'h1234_8765);
    wr(4'd11, 32'hFFFF_FFFF);
    rd(4'd9, r);  check("R10 inj hi readback", 64'(r), 64'hA5A5_0F0F);
    rd(4'd10, r); check("R10 inj lo readback", 64'(r), 64'h1234_8765);
    rd(4'd11, r); check("R10 inj ctl readback", 64'(r), 64'h1FF);

    // R11: single-bit sweep over data and check byte
    pat = 64'h0123_4567_89AB_CDEF;
    for (int b = 0; b < 64; b++) begin
      wr(4'd9, (b >= 32) ? (32'h1 << (b - 32)) : 32'h0);
      wr(4'd10, (b < 32) ? (32'h1 << b) : 32'h0);
      wr(4'd11, 32'h100);
      wr_valid = 1'b1; wr_data_in = pat; wr_ecc_in = 8'h3C; #1;
      check($sformatf("R11 data bit %0d", b), wr_data_out, pat ^ (64'h1 << b));
      check($sformatf("R11 ecc untouched bit %0d", b), 64'(wr_ecc_out), 64'h3C);
      wr_valid = 1'b0;
    end
    wr(4'd9, 32'h0); wr(4'd10, 32'h0);
    for (int e = 0; e < 8; e++) begin
      wr(4'd11, 32'h100 | (32'h1 << e));
      wr_valid = 1'b1; wr_ecc_in = 8'h3C; #1;
      check($sformatf("R11 ecc bit %0d", e), 64'(wr_ecc_out), 64'(8'h3C ^ (8'h1 << e)));
      wr_valid = 1'b0; #1;
      check($sformatf("R11 idle passthrough %0d", e), 64'(wr_ecc_out), 64'h3C);
    end
    wr(4'd9, 32'hFFFF_0000); wr(4'd10, 32'h0000_FFFF); wr(4'd11, 32'h0FF);
    wr_valid = 1'b1; wr_data_in = pat; #1;
    check("R11 disabled passthrough", wr_data_out, pat);
    wr_valid = 1'b0;
    wr(4'd11, 32'h1FF);
    beat(1'b0, 1'b1, pat, 16'h77, 36'h4);
    rd(4'd5, r); check("R11 read beat not corrupted", 64'(r), 64'h89AB_CDEF);
    wr(4'd0, 32'h3);

    // R12: unmapped offsets
    for (int a = 12; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), r); check($sformatf("R12 unmapped %0d", a), 64'(r), 64'h0);
    end
    rd(4'd0, r); check("R12 status untouched", 64'(r), 64'h0);
    rd(4'd1, r); check("R12 disable untouched", 64'(r), 64'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule